// File: doc/BRIEF.md
# Banked Memory ECC Control Unit

This unit sits between a memory-controller request port and a DRAM data path split into eight banks. On writes it appends eight SEC-DED check bits to each 64-bit data word. On reads it registers the returned 72-bit word, recomputes the syndrome, and either corrects a single-bit error or flags an error that cannot be corrected. The bank is taken from the top address bits. Configuration inputs set a global ECC switch and, for each bank, a check enable and a correction enable. A machine-check enable gates the uncorrectable-error output.

When ECC is globally on, every read gains exactly one clock, whatever the bank's own enables say. A partial write, meaning any byte strobe is clear, is turned into a read-modify-write: the old word is read, corrected when the bank allows it, merged with the new byte lanes, and written back whole with fresh check bits. A corrected error raises a one-cycle interrupt request. An uncorrectable error drives the active-low machine-check line low for at least two cycles.

The memory is a plain synchronous port. Read data returns in the cycle after a read strobe. Lane strobe bit 8 covers the check byte, held in write-data bits 71:64.

Top module: `ecc_bank_ctrl`

## Requirements
- R1: With `cfg_ecc_on`=0, read data is returned unchanged from memory bits 63:0, whatever the stored check bits are. `rsp_valid` rises 2 cycles after the accepting edge. `irq0` stays low and `mchk_n` stays high.
- R2: With `cfg_ecc_on`=0, a write drives `mem_wbe` = {0, `req_be`}, so the check lane (bit 8) is never written. A partial write completes in one cycle and `req_ready` stays high.
- R3: With `cfg_ecc_on`=1, every read response arrives 3 cycles after the accepting edge. This holds for every bank and every combination of per-bank enables.
- R4: With ECC on and the bank's check enable `cfg_bank_chk[bank]`=0 (bank = `req_addr[7:5]`), read data is delivered raw and no error is reported, whatever the correction bit says.
- R5: With ECC on, check enable 1 and correction enable `cfg_bank_cor[bank]`=0, read data is delivered raw and no error is reported.
- R6: With check and correction both enabled, a single flipped bit is corrected in any of the 72 stored positions (data 0..63, check 64..71). `irq0` pulses for exactly one cycle, in the same cycle as `rsp_valid`.
- R7: With check and correction enabled and `cfg_mchk_en`=1, a two-bit error delivers the raw data and drives `mchk_n` low for exactly 2 cycles, starting in the response cycle. `irq0` is not raised. After reset `mchk_n`=1 and `irq0`=0.
- R8: With `cfg_mchk_en`=0, an uncorrectable error leaves `mchk_n` high.
- R9: With ECC on, a full write (all eight `req_be` bits set) issues in its accept cycle with all nine lane strobes. `req_ready` stays high, and the word later reads back with no error reported.
- R10: With ECC on, a partial write drops `req_ready` for exactly 2 cycles. It reads the old word and corrects it when the bank allows (a correctable error raises `irq0`). It then writes the merged word with all nine lanes and fresh check bits. If the old word holds an uncorrectable error, `mchk_n` is pulsed and the merged word is still written, so a later read returns it with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ecc_on | input | 1 | Global ECC switch |
| cfg_bank_chk | input | 8 | Per-bank check enable |
| cfg_bank_cor | input | 8 | Per-bank correction enable |
| cfg_mchk_en | input | 1 | Enables machine-check signalling |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address, bits 7:5 select the bank |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte-lane strobes for the write |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 64 | Read data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address |
| mem_wbe | output | 9 | Lane strobes, bit 8 = check byte |
| mem_wdata | output | 72 | Write word, check bits at 71:64 |
| mem_rdata | input | 72 | Read word, one cycle after `mem_re` |
| irq0 | output | 1 | Correctable-error interrupt request |
| mchk_n | output | 1 | Active-low machine check |

## Verification
The embedded properties are checked on every cycle. They cover:
- response timing for both the bypass and the ECC pipeline;
- the decoder never reporting correctable and uncorrectable together;
- the read-modify-write phase always writing all nine lanes;
- the memory port never reading and writing in the same cycle;
- the machine-check low time never being shorter than two cycles, and the line only falling when its enable was set.

Only the bench scenarios can show the rest:
- data is actually corrected in every one of the 72 bit positions;
- the per-bank enable combinations select raw versus corrected data;
- a merged partial write carries the right lanes and the correction of the old word;
- a word written after an uncorrectable read reads back clean.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int WW = DW + CW;
  localparam int LANES = DW / 8;

  // Column for each data bit: distinct odd-weight bytes, weight 3 first, then weight 5
  function automatic logic [DW-1:0][CW-1:0] code_columns();
    logic [DW-1:0][CW-1:0] m;
    int n;
    m = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < 256; v++) begin
        if ($countones(8'(v)) == w && n < DW) begin
          m[n] = 8'(v);
          n++;
        end
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  localparam logic [DW-1:0][CW-1:0] COLS = code_columns();

  always_comb begin
    chk = '0;
    for (int i = 0; i < DW; i++) begin
      chk ^= COLS[i] & {CW{data[i]}};
    end
  end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_pkg::*;
(
  input  logic [WW-1:0] word,
  input  logic          fix_en,
  output logic [DW-1:0] dout,
  output logic          ce,
  output logic          ue
);
  localparam logic [DW-1:0][CW-1:0] COLS = code_columns();

  logic [CW-1:0] regen;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          hit;
  logic          chk_only;

  ecc_encoder u_regen (
    .data (word[DW-1:0]),
    .chk  (regen)
  );

  assign syn      = regen ^ word[WW-1:DW];
  assign chk_only = ($countones(syn) == 1);

  always_comb begin
    flip = '0;
    hit  = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (syn == COLS[i]) begin
        flip[i] = 1'b1;
        hit     = 1'b1;
      end
    end
  end

  assign ce   = fix_en && (syn != '0) && (hit || chk_only);
  assign ue   = fix_en && (syn != '0) && !(hit || chk_only);
  assign dout = fix_en ? (word[DW-1:0] ^ flip) : word[DW-1:0];
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic ce,
  input  logic ue,
  input  logic mchk_en,
  output logic irq0,
  output logic mchk_n
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic             low_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0  <= 1'b0;
      low_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      irq0 <= evt && ce;
      if (evt && ue && mchk_en) begin
        low_q <= 1'b1;
        cnt_q <= CNT_W'(HOLD - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        low_q <= 1'b0;
      end
    end
  end

  assign mchk_n = ~low_q;

  AST_MCHK_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(mchk_n) |=> !mchk_n); // R7
  AST_MCHK_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(mchk_n) |-> $past(mchk_en)); // R8
endmodule

// File: rtl/ecc_bank_ctrl.sv
module ecc_bank_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 3,
  parameter int MCHK_HOLD = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_ecc_on,
  input  logic [2**BANK_W-1:0] cfg_bank_chk,
  input  logic [2**BANK_W-1:0] cfg_bank_cor,
  input  logic                 cfg_mchk_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LANES:0]       mem_wbe,
  output logic [WW-1:0]        mem_wdata,
  input  logic [WW-1:0]        mem_rdata,
  output logic                 irq0,
  output logic                 mchk_n
);
  // stage 1: read issued, memory data arriving
  logic              s1_vld, s1_rmw, s1_ecc;
  logic [ADDR_W-1:0] s1_addr;
  logic [DW-1:0]     s1_wdata;
  logic [LANES-1:0]  s1_be;
  // stage 2: registered word entering the check tree
  logic              s2_vld, s2_rmw;
  logic [ADDR_W-1:0] s2_addr;
  logic [DW-1:0]     s2_wdata;
  logic [LANES-1:0]  s2_be;
  logic [WW-1:0]     s2_word;

  logic              acc, partial, do_rmw, rmw_wr, fix_en;
  logic [BANK_W-1:0] s2_bank;
  logic [DW-1:0]     dec_data, merged;
  logic              dec_ce, dec_ue;
  logic [CW-1:0]     req_chk, mrg_chk;

  assign req_ready = !(s1_vld && s1_rmw) && !(s2_vld && s2_rmw);
  assign acc       = req_valid && req_ready;
  assign partial   = req_write && !(&req_be);
  assign do_rmw    = acc && partial && cfg_ecc_on;
  assign rmw_wr    = s2_vld && s2_rmw;

  assign s2_bank = s2_addr[ADDR_W-1 -: BANK_W];
  assign fix_en  = cfg_bank_chk[s2_bank] && cfg_bank_cor[s2_bank];

  ecc_encoder u_enc_req (
    .data (req_wdata),
    .chk  (req_chk)
  );

  ecc_encoder u_enc_mrg (
    .data (merged),
    .chk  (mrg_chk)
  );

  ecc_decoder u_dec (
    .word   (s2_word),
    .fix_en (fix_en),
    .dout   (dec_data),
    .ce     (dec_ce),
    .ue     (dec_ue)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = s2_be[g] ? s2_wdata[g*8 +: 8] : dec_data[g*8 +: 8];
  end

  // memory port
  assign mem_re    = acc && (!req_write || do_rmw);
  assign mem_we    = rmw_wr || (acc && req_write && !do_rmw);
  assign mem_addr  = rmw_wr ? s2_addr : req_addr;
  assign mem_wdata = rmw_wr ? {mrg_chk, merged} : {req_chk, req_wdata};
  assign mem_wbe   = (rmw_wr || cfg_ecc_on) ? '1 : {1'b0, req_be};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_rmw <= 1'b0;
      s1_ecc <= 1'b0;
      s2_vld <= 1'b0;
      s2_rmw <= 1'b0;
    end else begin
      s1_vld <= mem_re;
      s1_rmw <= do_rmw;
      s1_ecc <= cfg_ecc_on;
      s2_vld <= s1_vld && s1_ecc;
      s2_rmw <= s1_vld && s1_rmw;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr  <= req_addr;
    s1_wdata <= req_wdata;
    s1_be    <= req_be;
    s2_addr  <= s1_addr;
    s2_wdata <= s1_wdata;
    s2_be    <= s1_be;
    s2_word  <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (s2_vld && !s2_rmw) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= dec_data;
    end else if (s1_vld && !s1_ecc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= mem_rdata[DW-1:0];
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  ecc_err_report #(.HOLD(MCHK_HOLD)) u_err (
    .clk     (clk),
    .rst     (rst),
    .evt     (s2_vld),
    .ce      (dec_ce),
    .ue      (dec_ue),
    .mchk_en (cfg_mchk_en),
    .irq0    (irq0),
    .mchk_n  (mchk_n)
  );

  AST_OFF_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_ecc) |=> rsp_valid); // R1
  AST_OFF_NO_CHECK_LANE: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !cfg_ecc_on && !rmw_wr) |-> !mem_wbe[LANES]); // R2
  AST_ON_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && !s2_rmw) |=> rsp_valid); // R3
  AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dec_ce && dec_ue)); // R6
  AST_PORT_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R9
  AST_RMW_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_rmw) |-> (mem_we && (&mem_wbe) && !req_ready)); // R10
endmodule

// File: tb/test_ecc_bank_ctrl.sv
`timescale 1ns/1ps
module test_ecc_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ecc_on = 1'b0;
  logic [7:0]  cfg_bank_chk = '0;
  logic [7:0]  cfg_bank_cor = '0;
  logic        cfg_mchk_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mem_re, mem_we;
  logic [7:0]  mem_addr;
  logic [8:0]  mem_wbe;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata;
  logic        irq0, mchk_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ecc_bank_ctrl i_ecc_bank_ctrl (
    .clk(clk), .rst(rst), .cfg_ecc_on(cfg_ecc_on), .cfg_bank_chk(cfg_bank_chk),
    .cfg_bank_cor(cfg_bank_cor), .cfg_mchk_en(cfg_mchk_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wbe(mem_wbe), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq0(irq0), .mchk_n(mchk_n)
  );

  // memory model: synchronous, lane strobes, one-cycle read
  logic [71:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) begin
      for (int l = 0; l < 9; l++) begin
        if (mem_wbe[l]) mem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      end
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [63:0] pat(input logic [7:0] a);
    return {a, ~a, 8'h5A, a ^ 8'h3C, 24'hC0DE00, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [63:0] d, input logic [7:0] be,
                      output logic [63:0] rd, output int lat, output int nrdy,
                      output int nirq, output int nmc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    rd = '0; lat = 0; nrdy = 0; nirq = 0; nmc = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (rsp_valid && lat == 0) begin lat = k; rd = rsp_rdata; end
      if (!req_ready) nrdy++;
      if (irq0) nirq++;
      if (!mchk_n) nmc++;
    end
  endtask

  task automatic set_bank(input int b, input logic c, input logic r);
    cfg_bank_chk[b] = c;
    cfg_bank_cor[b] = r;
  endtask

  // addr, chk, cor, flipA, flipB (FF = none), corrected, ce, ue
  localparam logic [28:0] VEC [8] = '{
    {8'h03, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0},
    {8'h24, 1'b1, 1'b1, 8'd5,  8'hFF, 1'b1, 1'b1, 1'b0},
    {8'h45, 1'b1, 1'b1, 8'd66, 8'hFF, 1'b1, 1'b1, 1'b0},
    {8'h66, 1'b1, 1'b1, 8'd7,  8'd40, 1'b0, 1'b0, 1'b1},
    {8'h87, 1'b1, 1'b0, 8'd12, 8'hFF, 1'b0, 1'b0, 1'b0},
    {8'hA8, 1'b0, 1'b1, 8'd63, 8'hFF, 1'b0, 1'b0, 1'b0},
    {8'hC9, 1'b1, 1'b1, 8'd63, 8'hFF, 1'b1, 1'b1, 1'b0},
    {8'hEA, 1'b0, 1'b0, 8'd0,  8'd1,  1'b0, 1'b0, 1'b0}
  };

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] rd, expd, fm;
    int lat, nrdy, nirq, nmc;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R1 reset rsp_valid low, ready high", {70'd0, rsp_valid, req_ready}, 72'd1);
    check(mchk_n && !irq0, "R7 reset mchk_n high, irq0 low", {70'd0, mchk_n, irq0}, 72'd2);

    // ---- ECC globally off ----
    cfg_ecc_on = 1'b0; cfg_bank_chk = '1; cfg_bank_cor = '1;
    mem[8'h11] = {8'h00, 64'h0123_4567_89AB_CDEF} ^ 72'h01_0000_0000_0000_0003;
    xfer(1'b0, 8'h11, '0, '0, rd, lat, nrdy, nirq, nmc);
    check(rd == 64'h0123_4567_89AB_CDEC, "R1 raw data with ECC off", {8'd0, rd}, {8'd0, 64'h0123_4567_89AB_CDEC});
    check(lat == 2, "R1 latency ECC off", 72'(lat), 72'd2);
    check(nirq == 0 && nmc == 0, "R1 no reporting ECC off", 72'(nirq + nmc), 72'd0);
    mem[8'h12] = {8'hA5, 64'h1111_1111_1111_1111};
    xfer(1'b1, 8'h12, 64'h2222_2222_2222_2222, 8'h0F, rd, lat, nrdy, nirq, nmc);
    check(nrdy == 0, "R2 partial write single cycle ECC off", 72'(nrdy), 72'd0);
    check(mem[8'h12] == {8'hA5, 64'h1111_1111_2222_2222}, "R2 lanes and check lane untouched",
          mem[8'h12], {8'hA5, 64'h1111_1111_2222_2222});

    // ---- vector table, ECC on ----
    cfg_ecc_on = 1'b1; cfg_mchk_en = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, fa, fb;
      a = VEC[v][28:21]; fa = VEC[v][18:11]; fb = VEC[v][10:3];
      set_bank(int'(a[7:5]), VEC[v][20], VEC[v][19]);
      xfer(1'b1, a, pat(a), 8'hFF, rd, lat, nrdy, nirq, nmc);
      check(nrdy == 0, "R9 full write no stall", 72'(nrdy), 72'd0);
      fm = '0;
      if (fa != 8'hFF) begin mem[a][fa] = ~mem[a][fa]; if (fa < 64) fm[fa] = 1'b1; end
      if (fb != 8'hFF) begin mem[a][fb] = ~mem[a][fb]; if (fb < 64) fm[fb] = 1'b1; end
      xfer(1'b0, a, '0, '0, rd, lat, nrdy, nirq, nmc);
      expd = VEC[v][2] ? pat(a) : (pat(a) ^ fm);
      check(rd == expd, "R4 R5 R6 R7 read data per bank enables", {8'd0, rd}, {8'd0, expd});
      check(lat == 3, "R3 uniform latency ECC on", 72'(lat), 72'd3);
      check(nirq == int'(VEC[v][1]), "R6 irq0 count", 72'(nirq), 72'(VEC[v][1]));
      check(nmc == (VEC[v][0] ? 2 : 0), "R7 mchk_n low cycles", 72'(nmc), VEC[v][0] ? 72'd2 : 72'd0);
    end

    // ---- walking single flips over all 72 positions ----
    set_bank(0, 1'b1, 1'b1);
    for (int b = 0; b < 72; b++) begin
      xfer(1'b1, 8'h05, pat(8'(b)), 8'hFF, rd, lat, nrdy, nirq, nmc);
      mem[8'h05][b] = ~mem[8'h05][b];
      xfer(1'b0, 8'h05, '0, '0, rd, lat, nrdy, nirq, nmc);
      check(rd == pat(8'(b)) && nirq == 1, $sformatf("R6 single flip bit %0d", b),
            {7'd0, nirq[0], rd}, {8'd1, pat(8'(b))});
    end

    // ---- machine check disabled ----
    cfg_mchk_en = 1'b0;
    xfer(1'b1, 8'h06, pat(8'h06), 8'hFF, rd, lat, nrdy, nirq, nmc);
    mem[8'h06][3] = ~mem[8'h06][3]; mem[8'h06][30] = ~mem[8'h06][30];
    xfer(1'b0, 8'h06, '0, '0, rd, lat, nrdy, nirq, nmc);
    check(nmc == 0 && nirq == 0, "R8 no machine check when disabled", 72'(nmc + nirq), 72'd0);
    cfg_mchk_en = 1'b1;

    // ---- read-modify-write with correctable old word ----
    xfer(1'b1, 8'h07, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF, rd, lat, nrdy, nirq, nmc);
    mem[8'h07][50] = ~mem[8'h07][50];
    xfer(1'b1, 8'h07, 64'h0000_0000_1234_5678, 8'h0F, rd, lat, nrdy, nirq, nmc);
    check(nrdy == 2, "R10 ready low two cycles", 72'(nrdy), 72'd2);
    check(nirq == 1 && nmc == 0, "R10 old word corrected with irq", 72'(nirq * 4 + nmc), 72'd4);
    check(mem[8'h07][71:64] != 8'h00 || mem[8'h07][63:0] == '0, "R10 check lane written", mem[8'h07], mem[8'h07]);
    xfer(1'b0, 8'h07, '0, '0, rd, lat, nrdy, nirq, nmc);
    check(rd == 64'hAAAA_BBBB_1234_5678 && nirq == 0, "R10 merged word reads back clean",
          {7'd0, nirq[0], rd}, {8'd0, 64'hAAAA_BBBB_1234_5678});

    // ---- read-modify-write with uncorrectable old word ----
    xfer(1'b1, 8'h08, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF, rd, lat, nrdy, nirq, nmc);
    mem[8'h08][9] = ~mem[8'h08][9]; mem[8'h08][10] = ~mem[8'h08][10];
    xfer(1'b1, 8'h08, 64'h0000_0000_0000_00EE, 8'h01, rd, lat, nrdy, nirq, nmc);
    check(nmc == 2 && nirq == 0, "R10 uncorrectable in read phase reported", 72'(nmc * 4 + nirq), 72'd8);
    xfer(1'b0, 8'h08, '0, '0, rd, lat, nrdy, nirq, nmc);
    check(rd == 64'h0F0F_0F0F_0F0F_09EE && nirq == 0 && nmc == 0, "R10 write proceeds with fresh check bits",
          {6'd0, nirq[0], nmc[0], rd}, {8'd0, 64'h0F0F_0F0F_0F0F_09EE});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule